// File: doc/BRIEF.md
# System Error Signalling Aggregator

This block gathers error events reported by the units of a host bridge and turns them into one registered, active-low system error output. Its event inputs are single-cycle pulses. They cover correctable and uncorrectable memory ECC errors, target aborts seen on cycles the bridge started (on the primary bus and on the graphics port), parity errors on either bus, and hits on invalid graphics translation-table entries. A built-in range comparator adds one more source. It flags a graphics-master access that lies outside the aperture and also falls either in the legacy hole or at or above top of memory.

Every source latches a sticky status bit, and software clears a bit by writing a one to it. The error output is qualified by one global enable and by an enable bit for each source. Target aborts produce a one-clock pulse on the output. Every other source holds the output asserted for as long as its status bit is set. ECC events that arrive while the initialisation flag is high are dropped.

Top module: `sys_err_agg`

## Requirements
- R1: While `glob_en` is low at a clock edge, `err_n` is high after that edge, whatever the events, enables and status.
- R2: A correctable ECC event (status bit 0) drives `err_n` low only when `src_en[0]` is set, and an uncorrectable ECC event (status bit 1) does so only when `src_en[1]` is set. In both cases `glob_en` must also be set.
- R3: An ECC event sampled while `init_active` is high sets no status bit and does not drive `err_n` low.
- R4: A target abort on the primary bus (bit 2) or on the graphics port (bit 3), when enabled, drives `err_n` low for exactly the one cycle after the event. The matching status bit stays set.
- R5: A primary-bus parity error (bit 4) or a graphics-port parity error (bit 5) sets its status bit and, when enabled, drives `err_n` low.
- R6: An invalid translation-table hit (bit 6) sets its status bit and, when enabled, drives `err_n` low.
- R7: With `gfx_acc_valid` high, bit 7 is set when the address satisfies two conditions. It lies outside [`aper_base`, `aper_base`+`aper_size`). It also lies in 0x000A0000..0x000FFFFF inclusive or is at or above `tom`.
- R8: Status bits are set on the edge after their event, whether or not they are enabled. They stay set until a clock edge where `clr_wr` is high and the matching `clr_mask` bit is one. A set in the same cycle wins over the clear.
- R9: For the level sources (bits 0, 1, 4, 5, 6 and 7), `err_n` stays low while the status bit and its enable are set and `glob_en` is high. It returns high on the edge after the clear.
- R10: During reset and for two clocks after `rst_n` rises, `status` is all zeros and `err_n` is high. `err_n` comes only from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global error signalling enable |
| src_en | input | 8 | Per-source enables, indexed as the status bits |
| init_active | input | 1 | Initialisation in progress; ECC events are dropped |
| ev_ecc_sb | input | 1 | Correctable ECC error pulse |
| ev_ecc_mb | input | 1 | Uncorrectable ECC error pulse |
| ev_pri_tabort | input | 1 | Target abort on a bridge-started primary-bus cycle |
| ev_gfx_tabort | input | 1 | Target abort on a bridge-started graphics-port cycle |
| ev_pri_perr | input | 1 | Primary-bus address or data parity error |
| ev_gfx_perr | input | 1 | Graphics-port address or data parity error |
| ev_gtt_invalid | input | 1 | Access to an invalid translation-table entry |
| gfx_acc_valid | input | 1 | Graphics-master access address is valid this cycle |
| gfx_acc_addr | input | 32 | Graphics-master access address |
| aper_base | input | 32 | Aperture base address |
| aper_size | input | 32 | Aperture size in bytes |
| tom | input | 32 | Top of memory |
| clr_wr | input | 1 | Status write strobe |
| clr_mask | input | 8 | Write-one-to-clear data for the status bits |
| status | output | 8 | Sticky status bits |
| err_n | output | 1 | Registered active-low system error |

## Verification
The bench builds the block with its defaults: a 32-bit address and a two-stage reset synchroniser. The comparator is therefore tested on real byte addresses. Directed accesses sit on each edge of the legacy hole, on top of memory and inside an aperture that overlaps the hole. The random phase mixes aperture placements with addresses drawn near those edges. It also mixes in clears, `init_active` and sparse enable patterns, so that set-versus-clear collisions and overlapping pulse and level sources occur many times.

// File: rtl/err_pkg.sv
package err_pkg;
  localparam int NSRC = 8;

  localparam int SRC_ECC_SB  = 0;
  localparam int SRC_ECC_MB  = 1;
  localparam int SRC_PRI_TA  = 2;
  localparam int SRC_GFX_TA  = 3;
  localparam int SRC_PRI_PE  = 4;
  localparam int SRC_GFX_PE  = 5;
  localparam int SRC_GTT_INV = 6;
  localparam int SRC_RANGE   = 7;

  typedef logic [NSRC-1:0] src_vec_t;

  // target aborts pulse the output; everything else holds it
  localparam src_vec_t PULSE_MASK = src_vec_t'((1 << SRC_PRI_TA) | (1 << SRC_GFX_TA));
  localparam src_vec_t LEVEL_MASK = ~PULSE_MASK;
endpackage

// File: rtl/err_rst_sync.sv
module err_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/err_addr_check.sv
module err_addr_check #(
  parameter int AW = 32
) (
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] aper_base,
  input  logic [AW-1:0] aper_size,
  input  logic [AW-1:0] tom,
  output logic          acc_bad
);
  localparam logic [AW:0] HOLE_LO = (AW+1)'(32'h000A_0000);
  localparam logic [AW:0] HOLE_HI = (AW+1)'(32'h000F_FFFF);

  logic [AW:0] addr_x, base_x, lim_x, tom_x;
  logic        in_aper, in_hole, above_tom;

  always_comb begin
    addr_x    = {1'b0, acc_addr};
    base_x    = {1'b0, aper_base};
    lim_x     = base_x + {1'b0, aper_size};
    tom_x     = {1'b0, tom};
    in_aper   = (addr_x >= base_x) && (addr_x < lim_x);
    in_hole   = (addr_x >= HOLE_LO) && (addr_x <= HOLE_HI);
    above_tom = (addr_x >= tom_x);
    acc_bad   = acc_valid && !in_aper && (in_hole || above_tom);
  end
endmodule

// File: rtl/err_status_bank.sv
module err_status_bank
  import err_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  logic     clr_wr,
  input  src_vec_t clr_mask,
  output src_vec_t stat_nxt,
  output src_vec_t stat_q
);
  src_vec_t clr_vec;
  logic     stat_en;

  always_comb begin
    clr_vec  = clr_wr ? clr_mask : '0;
    stat_nxt = (stat_q & ~clr_vec) | set_vec;
    stat_en  = (|set_vec) | clr_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_nxt;
  end
endmodule

// File: rtl/err_out_gen.sv
module err_out_gen
  import err_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     glob_en,
  input  src_vec_t src_en,
  input  src_vec_t stat_nxt,
  input  src_vec_t set_vec,
  output logic     err_n
);
  src_vec_t active_vec;
  logic     err_n_nxt;

  always_comb begin
    active_vec = ((stat_nxt & LEVEL_MASK) | (set_vec & PULSE_MASK)) & src_en;
    err_n_nxt  = !(glob_en && (|active_vec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_n <= 1'b1;
    else        err_n <= err_n_nxt;
  end
endmodule

// File: rtl/sys_err_agg.sv
module sys_err_agg
  import err_pkg::*;
#(
  parameter int AW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glob_en,
  input  logic [NSRC-1:0] src_en,
  input  logic            init_active,
  input  logic            ev_ecc_sb,
  input  logic            ev_ecc_mb,
  input  logic            ev_pri_tabort,
  input  logic            ev_gfx_tabort,
  input  logic            ev_pri_perr,
  input  logic            ev_gfx_perr,
  input  logic            ev_gtt_invalid,
  input  logic            gfx_acc_valid,
  input  logic [AW-1:0]   gfx_acc_addr,
  input  logic [AW-1:0]   aper_base,
  input  logic [AW-1:0]   aper_size,
  input  logic [AW-1:0]   tom,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] status,
  output logic            err_n
);
  logic     srst_n;
  logic     range_bad;
  src_vec_t set_vec;
  src_vec_t stat_nxt;

  err_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  err_addr_check #(.AW(AW)) u_range (
    .acc_valid (gfx_acc_valid),
    .acc_addr  (gfx_acc_addr),
    .aper_base (aper_base),
    .aper_size (aper_size),
    .tom       (tom),
    .acc_bad   (range_bad)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[SRC_ECC_SB]  = ev_ecc_sb && !init_active;
    set_vec[SRC_ECC_MB]  = ev_ecc_mb && !init_active;
    set_vec[SRC_PRI_TA]  = ev_pri_tabort;
    set_vec[SRC_GFX_TA]  = ev_gfx_tabort;
    set_vec[SRC_PRI_PE]  = ev_pri_perr;
    set_vec[SRC_GFX_PE]  = ev_gfx_perr;
    set_vec[SRC_GTT_INV] = ev_gtt_invalid;
    set_vec[SRC_RANGE]   = range_bad;
  end

  err_status_bank u_stat (
    .clk      (clk),
    .rst_n    (srst_n),
    .set_vec  (set_vec),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .stat_nxt (stat_nxt),
    .stat_q   (status)
  );

  err_out_gen u_out (
    .clk      (clk),
    .rst_n    (srst_n),
    .glob_en  (glob_en),
    .src_en   (src_en),
    .stat_nxt (stat_nxt),
    .set_vec  (set_vec),
    .err_n    (err_n)
  );
endmodule

// File: rtl/sys_err_agg_chk.sv
module sys_err_agg_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          srst_n,
  input logic          glob_en,
  input logic [7:0]    src_en,
  input logic          init_active,
  input logic          ev_pri_tabort,
  input logic          ev_gfx_tabort,
  input logic          ev_gtt_invalid,
  input logic          gfx_acc_valid,
  input logic [AW-1:0] gfx_acc_addr,
  input logic [AW-1:0] tom,
  input logic          clr_wr,
  input logic [7:0]    clr_mask,
  input logic [7:0]    status,
  input logic          err_n
);
  p_glob_gate_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !glob_en |=> err_n);

  p_ecc_sb_init_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (init_active && !status[0]) |=> !status[0]);

  p_ecc_mb_init_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (init_active && !status[1]) |=> !status[1]);

  p_pri_abort_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (ev_pri_tabort && glob_en && src_en[2]) |=> !err_n);

  p_gfx_abort_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (ev_gfx_tabort && glob_en && src_en[3]) |=> (!err_n && status[3]));

  p_low_addr_ok_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (gfx_acc_valid && gfx_acc_addr < AW'(32'h000A_0000) && gfx_acc_addr < tom && !status[7])
      |=> !status[7]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (status[6] && !(clr_wr && clr_mask[6])) |=> status[6]);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (clr_wr && clr_mask[6] && !ev_gtt_invalid) |=> !status[6]);

  p_level_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (glob_en && src_en[6] && status[6] && !(clr_wr && clr_mask[6])) |=> !err_n);
endmodule

bind sys_err_agg sys_err_agg_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .srst_n         (srst_n),
  .glob_en        (glob_en),
  .src_en         (src_en),
  .init_active    (init_active),
  .ev_pri_tabort  (ev_pri_tabort),
  .ev_gfx_tabort  (ev_gfx_tabort),
  .ev_gtt_invalid (ev_gtt_invalid),
  .gfx_acc_valid  (gfx_acc_valid),
  .gfx_acc_addr   (gfx_acc_addr),
  .tom            (tom),
  .clr_wr         (clr_wr),
  .clr_mask       (clr_mask),
  .status         (status),
  .err_n          (err_n)
);

// File: tb/sys_err_agg_bench.sv
`timescale 1ns/1ps
module sys_err_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        glob_en, init_active;
  logic [7:0]  src_en, clr_mask;
  logic        ev_ecc_sb, ev_ecc_mb, ev_pri_tabort, ev_gfx_tabort;
  logic        ev_pri_perr, ev_gfx_perr, ev_gtt_invalid;
  logic        gfx_acc_valid, clr_wr;
  logic [31:0] gfx_acc_addr, aper_base, aper_size, tom;
  logic [7:0]  status;
  logic        err_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] m_stat;
  logic       m_err;

  always #4 clk = ~clk;

  sys_err_agg u_sys_err_agg (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .src_en(src_en),
    .init_active(init_active), .ev_ecc_sb(ev_ecc_sb), .ev_ecc_mb(ev_ecc_mb),
    .ev_pri_tabort(ev_pri_tabort), .ev_gfx_tabort(ev_gfx_tabort),
    .ev_pri_perr(ev_pri_perr), .ev_gfx_perr(ev_gfx_perr),
    .ev_gtt_invalid(ev_gtt_invalid), .gfx_acc_valid(gfx_acc_valid),
    .gfx_acc_addr(gfx_acc_addr), .aper_base(aper_base), .aper_size(aper_size),
    .tom(tom), .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status), .err_n(err_n)
  );

  // R7 expectation
  function automatic logic range_bad(input logic [31:0] a, b, s, t);
    logic [32:0] lim;
    logic in_ap, hole;
    lim   = {1'b0, b} + {1'b0, s};
    in_ap = ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < lim);
    hole  = (a >= 32'h000A_0000) && (a <= 32'h000F_FFFF);
    return !in_ap && (hole || a >= t);
  endfunction

  function automatic logic [7:0] ev_vec();
    logic [7:0] v;
    v[0] = ev_ecc_sb && !init_active;
    v[1] = ev_ecc_mb && !init_active;
    v[2] = ev_pri_tabort;
    v[3] = ev_gfx_tabort;
    v[4] = ev_pri_perr;
    v[5] = ev_gfx_perr;
    v[6] = ev_gtt_invalid;
    v[7] = gfx_acc_valid && range_bad(gfx_acc_addr, aper_base, aper_size, tom);
    return v;
  endfunction

  task automatic check(input string tag);
    total++;
    if (err_n !== m_err) begin
      bad++;
      $display("FAIL %s err_n act=%b exp=%b", tag, err_n, m_err);
    end
    total++;
    if (status !== m_stat) begin
      bad++;
      $display("FAIL %s status act=%h exp=%h", tag, status, m_stat);
    end
  endtask

  task automatic cyc(input string tag);
    logic [7:0] s, n;
    @(posedge clk);
    s = ev_vec();
    n = (m_stat & ~(clr_wr ? clr_mask : 8'h00)) | s;
    m_err  = !(glob_en && (|(((n & 8'hF3) | (s & 8'h0C)) & src_en)));
    m_stat = n;
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    {ev_ecc_sb, ev_ecc_mb, ev_pri_tabort, ev_gfx_tabort} = '0;
    {ev_pri_perr, ev_gfx_perr, ev_gtt_invalid, gfx_acc_valid} = '0;
    clr_wr = 1'b0; clr_mask = '0;
  endtask

  task automatic clear_all(input string tag);
    clr_wr = 1'b1; clr_mask = 8'hFF;
    cyc(tag);
    clr_wr = 1'b0; clr_mask = '0;
  endtask

  task automatic probe(input logic [31:0] a);
    gfx_acc_valid = 1'b1; gfx_acc_addr = a;
    cyc("R7 range");
    gfx_acc_valid = 1'b0;
    clear_all("R7 clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    glob_en = 1'b0; init_active = 1'b0; src_en = '0;
    aper_base = 32'h000E_0000; aper_size = 32'h0001_0000; tom = 32'h1000_0000;
    gfx_acc_addr = '0;
    quiet();
    m_stat = '0; m_err = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 sync release");
    @(negedge clk);
    @(negedge clk);
    check("R10 after release");

    glob_en = 1'b1; src_en = 8'hFF;
    ev_ecc_sb = 1'b1; cyc("R2 correctable");
    ev_ecc_sb = 1'b0; cyc("R9 hold");
    clr_wr = 1'b1; clr_mask = 8'h01; cyc("R8 w1c");
    clr_wr = 1'b0; clr_mask = '0; cyc("R9 released");

    src_en = 8'hFE;
    ev_ecc_sb = 1'b1; cyc("R2 masked"); ev_ecc_sb = 1'b0;
    clear_all("R8 clear");
    src_en = 8'hFD;
    ev_ecc_mb = 1'b1; cyc("R2 mb masked"); ev_ecc_mb = 1'b0;
    clear_all("R8 clear");
    src_en = 8'hFF;
    ev_ecc_mb = 1'b1; cyc("R2 uncorrectable"); ev_ecc_mb = 1'b0;
    clear_all("R8 clear");

    init_active = 1'b1;
    ev_ecc_mb = 1'b1; ev_ecc_sb = 1'b1; cyc("R3 init drop");
    ev_ecc_mb = 1'b0; ev_ecc_sb = 1'b0; cyc("R3 init after");
    init_active = 1'b0;

    ev_pri_tabort = 1'b1; cyc("R4 primary pulse");
    ev_pri_tabort = 1'b0; cyc("R4 primary one clock");
    ev_gfx_tabort = 1'b1; cyc("R4 graphics pulse");
    ev_gfx_tabort = 1'b0; cyc("R4 graphics one clock");
    clear_all("R8 clear");

    ev_pri_perr = 1'b1; cyc("R5 primary parity"); ev_pri_perr = 1'b0; cyc("R5 hold");
    clear_all("R8 clear");
    ev_gfx_perr = 1'b1; cyc("R5 graphics parity"); ev_gfx_perr = 1'b0; cyc("R5 hold");
    clear_all("R8 clear");
    ev_gtt_invalid = 1'b1; cyc("R6 table hit"); ev_gtt_invalid = 1'b0;
    clr_wr = 1'b1; clr_mask = 8'h40; ev_gtt_invalid = 1'b1; cyc("R8 set wins");
    ev_gtt_invalid = 1'b0; clr_wr = 1'b0; clr_mask = '0;
    glob_en = 1'b0; cyc("R1 global off");
    glob_en = 1'b1; cyc("R1 global on");
    clear_all("R8 clear");

    probe(32'h0009_FFFF);
    probe(32'h000A_0000);
    probe(32'h000E_8000);
    probe(32'h000F_FFFF);
    probe(32'h0010_0000);
    probe(32'h0FFF_FFFF);
    probe(32'h1000_0000);

    for (int i = 0; i < 4000; i++) begin
      glob_en       = ($urandom_range(0, 9) != 0);
      init_active   = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 15) == 0) src_en = 8'($urandom);
      ev_ecc_sb     = ($urandom_range(0, 11) == 0);
      ev_ecc_mb     = ($urandom_range(0, 11) == 0);
      ev_pri_tabort = ($urandom_range(0, 11) == 0);
      ev_gfx_tabort = ($urandom_range(0, 11) == 0);
      ev_pri_perr   = ($urandom_range(0, 15) == 0);
      ev_gfx_perr   = ($urandom_range(0, 15) == 0);
      ev_gtt_invalid= ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 63) == 0) begin
        aper_base = 32'($urandom_range(0, 15)) << 16;
        aper_size = 32'($urandom_range(0, 4)) << 16;
        tom       = 32'($urandom_range(1, 32)) << 16;
      end
      gfx_acc_valid = ($urandom_range(0, 3) == 0);
      gfx_acc_addr  = (32'($urandom_range(0, 40)) << 15) + 32'($urandom_range(0, 2)) - 32'd1;
      clr_wr        = ($urandom_range(0, 3) == 0);
      clr_mask      = 8'($urandom);
      cyc("random R1 R5 R7 R8 R9");
    end
    quiet();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule